// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler with Power-Up Wake-Up

This block keeps a 2K-refresh dynamic memory alive. A free-running interval timer creates one refresh obligation per average refresh slot (2,048 rows in 32 ms gives roughly 15.6 us per slot). The block asks the access sequencer for the memory bus with a request line, waits for a grant, and then drives the row and column strobes itself. Each refresh cycle pulls the column strobe low before the row strobe. The memory's internal row counter supplies the address, so the block drives no address, data, write-enable or output-enable pins.

After reset the block waits a programmable power-up pause. It then runs a burst of wake-up refresh cycles. Only after that burst does it raise `ready_o`, which tells the access sequencer that normal traffic may start. Obligations that cannot be served while the sequencer holds the bus are kept in a small debt counter. The block pays them back to back once the grant arrives. If the debt reaches a programmable limit, the refresh deadline is treated as missed. The block then drops `ready_o`, discards the debt, and replays the full wake-up burst.

All durations are parameters counted in clock cycles: `PAUSE_CYC`, `INTERVAL_CYC`, `WAKE_CYCLES`, `CSR_CYC`, `RAS_CYC`, `RP_CYC` and `DEBT_LIMIT`.

Top module: `refresh_sched`

## Requirements
- R1: While `rst_n` is low, `ras_n_o` and `cas_n_o` are 1, and `ref_req_o` and `ready_o` are 0.
- R2: After reset is released, `ref_req_o` stays low for the power-up pause and first rises on the `PAUSE_CYC`-th rising clock edge. No strobe moves before then, even if the grant is held high.
- R3: The wake-up burst has exactly `WAKE_CYCLES` refresh cycles. `ready_o` stays low until it rises on the edge that ends the last cycle's precharge. Each cycle is `CSR_CYC+RAS_CYC+RP_CYC+1` clocks when granted back to back.
- R4: Every refresh cycle keeps `cas_n_o`=0 with `ras_n_o`=1 for exactly `CSR_CYC` clocks, then holds both low for exactly `RAS_CYC` clocks. Both strobes are then high for at least `RP_CYC` clocks before the column strobe falls again.
- R5: `ras_n_o` is never 0 while `cas_n_o` is 1.
- R6: A refresh cycle starts only on an edge where `ref_req_o` and `ref_gnt_i` are both 1. Once raised, `ref_req_o` stays high until the precharge of a cycle ends.
- R7: A started refresh cycle always runs to the end of its precharge, even if `ref_gnt_i` is withdrawn.
- R8: While `ready_o` is 1, the timer adds one obligation every `INTERVAL_CYC` clocks. With no prior debt, `ref_req_o` rises exactly `INTERVAL_CYC` clocks after `ready_o` rises. The timer is halted while `ready_o` is 0.
- R9: If k obligations build up while the grant is low, with k below `DEBT_LIMIT`, exactly k refresh cycles follow the grant. After them `ref_req_o` falls and `ready_o` stays 1.
- R10: When the debt would reach `DEBT_LIMIT`, `ready_o` falls on that edge and the debt is discarded. Exactly `WAKE_CYCLES` cycles are then issued before `ready_o` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_gnt_i | input | 1 | Bus grant from the access sequencer |
| ref_req_o | output | 1 | Bus request for a refresh cycle |
| ras_n_o | output | 1 | Row strobe to the memory, active low |
| cas_n_o | output | 1 | Column strobe to the memory, active low |
| ready_o | output | 1 | Memory initialised and refresh on schedule |

## Verification
On every clock, the embedded properties check that:
- the strobes are ordered column-first;
- the row strobe never falls alone;
- a cycle starts only under request and grant, is never abandoned, and holds its request;
- the pause stays quiet;
- `ready_o` rises only at a cycle completion and drops after a missed deadline;
- the debt never underflows.

Exact counts can only be shown by the bench scenarios:
- the length of the pause;
- the number of wake-up and replay cycles;
- the clock-accurate strobe widths;
- the interval timing after `ready_o`;
- the number of cycles issued for a given build-up of debt.

// File: rtl/refr_pkg.sv
package refr_pkg;

    typedef enum logic [1:0] {
        CY_IDLE = 2'd0,
        CY_CSR  = 2'd1,
        CY_ACT  = 2'd2,
        CY_PRE  = 2'd3
    } cyc_state_e;

    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_WAKE  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

endpackage

// File: rtl/refr_interval_timer.sv
module refr_interval_timer #(
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == LAST) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tick_o = run_i && (tmr_q.cnt == LAST);

endmodule

// File: rtl/refr_debt.sv
module refr_debt #(
    parameter int LIMIT = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_i,
    input  logic                         paid_i,
    output logic [$clog2(LIMIT+1)-1:0]   level_o,
    output logic                         hit_o
);
    localparam int W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [W-1:0] level;
    } debt_s;

    debt_s debt_d, debt_q;
    logic [W:0] sum;

    always_comb begin
        debt_d = debt_q;
        sum    = {1'b0, debt_q.level} + (W+1)'(tick_i) - (W+1)'(paid_i);
        hit_o  = (sum == (W+1)'(LIMIT));
        if (hit_o) debt_d.level = '0;
        else       debt_d.level = sum[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) debt_q <= '0;
        else        debt_q <= debt_d;
    end

    assign level_o = debt_q.level;

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paid_i |-> (debt_q.level != '0));

endmodule

// File: rtl/refr_cbr_fsm.sv
module refr_cbr_fsm
    import refr_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int RAS_CYC = 5,
    parameter int RP_CYC  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic gnt_i,
    output logic req_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic done_o
);
    localparam int M1 = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
    localparam int MX = (M1 > RP_CYC) ? M1 : RP_CYC;
    localparam int CW = $clog2(MX + 1);

    typedef struct packed {
        cyc_state_e    state;
        logic [CW-1:0] cnt;
        logic          ras_n;
        logic          cas_n;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            CY_IDLE: begin
                if (pending_i && gnt_i) begin
                    fsm_d.state = CY_CSR;
                    fsm_d.cnt   = CW'(CSR_CYC - 1);
                end
            end
            CY_CSR: begin
                if (fsm_q.cnt == '0) begin
                    fsm_d.state = CY_ACT;
                    fsm_d.cnt   = CW'(RAS_CYC - 1);
                end else begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end
            end
            CY_ACT: begin
                if (fsm_q.cnt == '0) begin
                    fsm_d.state = CY_PRE;
                    fsm_d.cnt   = CW'(RP_CYC - 1);
                end else begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end
            end
            CY_PRE: begin
                if (fsm_q.cnt == '0) begin
                    fsm_d.state = CY_IDLE;
                    fsm_d.cnt   = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end
            end
            default: fsm_d.state = CY_IDLE;
        endcase
        fsm_d.cas_n = !((fsm_d.state == CY_CSR) || (fsm_d.state == CY_ACT));
        fsm_d.ras_n = !(fsm_d.state == CY_ACT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q       <= '0;
            fsm_q.state <= CY_IDLE;
            fsm_q.ras_n <= 1'b1;
            fsm_q.cas_n <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign req_o   = (fsm_q.state != CY_IDLE) || pending_i;
    assign ras_n_o = fsm_q.ras_n;
    assign cas_n_o = fsm_q.cas_n;
    assign done_o  = (fsm_q.state == CY_PRE) && (fsm_q.cnt == '0);

    // R4
    cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> !$past(cas_n_o));

    // R5
    no_row_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_o |-> !cas_n_o);

    // R6
    grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n_o) |-> $past(req_o && gnt_i));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> $past((fsm_q.state == CY_IDLE) || done_o));

    // R7
    no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.state != CY_IDLE) && !done_o) |=> (fsm_q.state != CY_IDLE));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refr_pkg::*;
#(
    parameter int INTERVAL_CYC = 1560,
    parameter int PAUSE_CYC    = 20000,
    parameter int WAKE_CYCLES  = 8,
    parameter int CSR_CYC      = 1,
    parameter int RAS_CYC      = 5,
    parameter int RP_CYC       = 3,
    parameter int DEBT_LIMIT   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt_i,
    output logic ref_req_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic ready_o
);
    localparam int PW = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1;
    localparam int WW = $clog2(WAKE_CYCLES + 1);
    localparam int DW = $clog2(DEBT_LIMIT + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);

    typedef struct packed {
        phase_e        phase;
        logic [PW-1:0] pause_cnt;
        logic [WW-1:0] wake_left;
        logic          ready;
    } top_s;

    top_s top_d, top_q;

    logic          tick;
    logic          cyc_done;
    logic          pending;
    logic          debt_hit;
    logic [DW-1:0] debt_level;

    refr_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (top_q.ready),
        .tick_o (tick)
    );

    refr_debt #(.LIMIT(DEBT_LIMIT)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .paid_i  (cyc_done && (top_q.phase == PH_RUN)),
        .level_o (debt_level),
        .hit_o   (debt_hit)
    );

    assign pending = (top_q.phase == PH_WAKE) ||
                     ((top_q.phase == PH_RUN) && (debt_level != '0));

    refr_cbr_fsm #(.CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .gnt_i     (ref_gnt_i),
        .req_o     (ref_req_o),
        .ras_n_o   (ras_n_o),
        .cas_n_o   (cas_n_o),
        .done_o    (cyc_done)
    );

    always_comb begin
        top_d = top_q;
        unique case (top_q.phase)
            PH_PAUSE: begin
                if (top_q.pause_cnt == PAUSE_LAST) begin
                    top_d.phase     = PH_WAKE;
                    top_d.wake_left = WW'(WAKE_CYCLES);
                    top_d.pause_cnt = '0;
                end else begin
                    top_d.pause_cnt = top_q.pause_cnt + 1'b1;
                end
            end
            PH_WAKE: begin
                if (cyc_done) begin
                    top_d.wake_left = top_q.wake_left - 1'b1;
                    if (top_q.wake_left == WW'(1)) begin
                        top_d.phase = PH_RUN;
                        top_d.ready = 1'b1;
                    end
                end
            end
            PH_RUN: begin
                if (debt_hit) begin
                    top_d.phase     = PH_WAKE;
                    top_d.wake_left = WW'(WAKE_CYCLES);
                    top_d.ready     = 1'b0;
                end
            end
            default: top_d.phase = PH_PAUSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q       <= '0;
            top_q.phase <= PH_PAUSE;
        end else begin
            top_q <= top_d;
        end
    end

    assign ready_o = top_q.ready;

    // R2
    pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.phase == PH_PAUSE) |-> (!ref_req_o && ras_n_o && cas_n_o));

    // R3
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(cyc_done));

    // R10
    miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        debt_hit |=> !ready_o);

endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
    localparam int INTERVAL = 100;
    localparam int PAUSE    = 50;
    localparam int WAKE     = 8;
    localparam int CSR      = 1;
    localparam int RASW     = 4;
    localparam int RP       = 3;
    localparam int LIMIT    = 6;
    localparam int PERIOD   = CSR + RASW + RP + 1;

    // columns: obligations built up, expected cycles, expected ready drop
    localparam int NVEC = 5;
    localparam int VEC [NVEC][3] = '{
        '{1, 1, 0},
        '{3, 3, 0},
        '{LIMIT, WAKE, 1},
        '{5, 5, 0},
        '{2, 2, 0}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic gnt;
    logic req, ras_n, cas_n, ready;

    int tests = 0;
    int fails = 0;
    int ras_falls = 0;

    always #5 clk = ~clk;

    refresh_sched #(
        .INTERVAL_CYC(INTERVAL), .PAUSE_CYC(PAUSE), .WAKE_CYCLES(WAKE),
        .CSR_CYC(CSR), .RAS_CYC(RASW), .RP_CYC(RP), .DEBT_LIMIT(LIMIT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ref_gnt_i(gnt),
        .ref_req_o(req), .ras_n_o(ras_n), .cas_n_o(cas_n), .ready_o(ready)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // strobe monitor (R4, R5)
    logic prev_ras = 1'b1, prev_cas = 1'b1;
    int csr_len = 0, ras_len = 0, high_len = 0;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (!ras_n && cas_n) chk(1'b0, "R5 row strobe low alone", 1, 0);
            if (!cas_n && prev_cas && ras_falls > 0)
                chk(high_len >= RP, "R4 precharge width", high_len, RP);
            if (!ras_n && prev_ras) begin
                ras_falls++;
                chk(!prev_cas && csr_len == CSR, "R4 column lead", csr_len, CSR);
            end
            if (ras_n && !prev_ras) begin
                chk(ras_len == RASW, "R4 row low width", ras_len, RASW);
                ras_len = 0;
                csr_len = 0;
            end
            if (!cas_n && ras_n) csr_len++;
            if (!ras_n) ras_len++;
            if (ras_n && cas_n) high_len++; else high_len = 0;
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    task automatic wait_req(input logic val, input int limit, output int n);
        n = 0;
        while (req !== val && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_ready(input logic val, input int limit, output int n);
        n = 0;
        while (ready !== val && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        finish_run();
    end

    initial begin
        int n, base;
        rst_n = 1'b0;
        gnt   = 1'b1;
        repeat (3) @(negedge clk);
        // R1
        chk(ras_n === 1'b1 && cas_n === 1'b1, "R1 strobes in reset", {ras_n, cas_n}, 3);
        chk(req === 1'b0 && ready === 1'b0, "R1 req/ready in reset", {req, ready}, 0);
        rst_n = 1'b1;

        // R2: pause length, grant held high has no effect
        wait_req(1'b1, 1000, n);
        chk(n == PAUSE, "R2 pause length", n, PAUSE);
        chk(ras_falls == 0 && ready == 1'b0, "R2 quiet during pause", ras_falls, 0);

        // R3: wake-up burst
        wait_ready(1'b1, 1000, n);
        chk(n == WAKE * PERIOD, "R3 ready timing", n, WAKE * PERIOD);
        chk(ras_falls == WAKE, "R3 wake cycle count", ras_falls, WAKE);
        chk(req == 1'b0, "R3 no request after wake", req, 0);

        // R8: first obligation one interval after ready
        base = ras_falls;
        wait_req(1'b1, 1000, n);
        chk(n == INTERVAL, "R8 interval after ready", n, INTERVAL);
        wait_req(1'b0, 1000, n);
        chk(ras_falls - base == 1, "R8 one cycle served", ras_falls - base, 1);

        // R9 / R10 vector table
        for (int i = 0; i < NVEC; i++) begin
            gnt = 1'b0;
            wait_req(1'b1, 1000, n);
            base = ras_falls;
            repeat ((VEC[i][0] - 1) * INTERVAL) @(negedge clk);
            if (VEC[i][2] != 0)
                chk(ready == 1'b0, "R10 ready dropped on missed deadline", ready, 0);
            else
                chk(ready == 1'b1, "R9 ready kept under debt", ready, 1);
            chk(ras_falls == base, "R9 nothing issued without grant", ras_falls - base, 0);
            gnt = 1'b1;
            n = 0;
            @(negedge clk);
            while (!(req == 1'b0 && ready == 1'b1) && n < 2000) begin
                @(negedge clk);
                n++;
            end
            chk(ras_falls - base == VEC[i][1], (VEC[i][2] != 0) ? "R10 replay count" : "R9 drain count",
                ras_falls - base, VEC[i][1]);
        end

        // R7: cycle completes after grant withdrawn
        gnt = 1'b0;
        wait_req(1'b1, 1000, n);
        repeat (INTERVAL) @(negedge clk);
        base = ras_falls;
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        repeat (3 * PERIOD) @(negedge clk);
        chk(ras_falls - base == 1, "R7 started cycle completed", ras_falls - base, 1);
        chk(req == 1'b1, "R6 request held with debt left", req, 1);
        gnt = 1'b1;
        wait_req(1'b0, 1000, n);
        chk(ras_falls - base == 2, "R7 remaining debt paid", ras_falls - base, 2);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule